// File: doc/BRIEF.md
# Indirect SRAM Access Port

This block gives a host processor access to a local byte-wide SRAM using I/O cycles only, so the host needs no memory address decode. The host first writes an index into a select port, and this index chooses one of a few internal registers. Accesses to the data port then go to that register. One index is the data window into the SRAM. Two more indexes hold the SRAM address pointer, which is 17 bits wide and covers 128 KB.

A host access to the data window becomes one byte cycle on the SRAM, or two byte cycles for a 16-bit transfer. The lower address is accessed first. `host_ready` stays low until every byte cycle has finished. After each data-window transfer the pointer moves forward, so the host can stream through consecutive SRAM bytes without rewriting the pointer. An input for an external memory-match decode is present for pin compatibility but has no effect.

Top module: `sram_ioport`

## Requirements
- R1: While `rst_n` is low, and after it is released, `host_ready` is 1, `host_rdata` is 0, all three SRAM strobes are 1 (inactive), and the index and the pointer are both 0.
- R2: A host write with `host_dport`=0 loads `host_wdata[3:0]` into the index and ignores the upper bits. A host read with `host_dport`=0 returns the index zero-extended to 16 bits in `host_rdata` one clock after the request. `host_ready` never drops for either access.
- R3: Index 1 reads and writes pointer bits 15:0, and index 2 reads and writes pointer bit 16 in data bit 0. A read of index 3 to 15 returns 0, and a write to any of them changes no state. Register writes use all 16 data bits whatever `host_wide` is.
- R4: A 16-bit read of index 0 runs two byte cycles, first at the pointer and then at pointer+1. It returns {byte at pointer+1, byte at pointer}, and it holds `host_ready` low for 2×ACC_CYC clocks.
- R5: An 8-bit read of index 0 runs one byte cycle at the pointer. It returns {8'h00, byte}, and it holds `host_ready` low for ACC_CYC clocks.
- R6: A 16-bit write of index 0 stores `host_wdata[7:0]` at the pointer and `host_wdata[15:8]` at pointer+1. An 8-bit write stores `host_wdata[7:0]` only. `sram_we_n` is low in every clock of a byte cycle except its last one.
- R7: When a data-window transfer completes, the pointer moves forward by 2 for a 16-bit transfer and by 1 for an 8-bit one, modulo 2^17. A 16-bit access at 0x1FFFF reaches 0x1FFFF and then 0x00000.
- R8: A request made while `host_ready` is 0 is ignored. `host_rdata` does not change while `host_ready` is 0.
- R9: `smem_match_n` has no effect on any output or any state.
- R10: `sram_ce_n` is low exactly while `host_ready` is 0. `sram_oe_n` is low only during read transfers, and it is never low at the same time as `sram_we_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | One-clock request strobe, taken only while host_ready is 1 |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_dport | input | 1 | 0 = index select port, 1 = data port |
| host_wide | input | 1 | 1 = 16-bit transfer, 0 = 8-bit (data window only) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, held until the next read completes |
| host_ready | output | 1 | 1 = idle; 0 while a data-window transfer is in progress |
| smem_match_n | input | 1 | Memory-match decode input, ignored (tie high) |
| sram_addr | output | 17 | SRAM byte address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The data window is tested with 16-bit and 8-bit reads and writes. These tell apart the byte order, the one- and two-cycle lengths of the `host_ready` wait, and the pointer step of 2 versus 1. Accesses at pointer 0x1FFFF separate a correct 17-bit wrap from one that carries into a missing bit or stops short. Register traffic with oversized index values and writes to unused indexes shows that only the defined fields hold state. Requests made during a busy transfer, and a toggling `smem_match_n`, show that neither input changes anything the cycle-by-cycle model predicts.

// File: rtl/sram_ioport_pkg.sv
// Shared types and register index values for the indirect SRAM access port.
// Assumes that no other package defines the same names.
package sram_ioport_pkg;

    // Byte sequencer phases: idle, low byte cycle, high byte cycle.
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LO   = 2'd1,
        SQ_HI   = 2'd2
    } seq_state_t;

    // Register indexes behind the data port.
    localparam int IDX_WINDOW = 0;
    localparam int IDX_PTR_LO = 1;
    localparam int IDX_PTR_HI = 2;

endpackage

// File: rtl/sram_ioport_regs.sv
// Index register, SRAM address pointer and register read mux.
// Assumes acc_en is high for exactly one clock per accepted host request,
// and that adv_en never coincides with acc_en (the top blocks requests while busy).
module sram_ioport_regs
    import sram_ioport_pkg::*;
#(
    parameter int AW   = 17,
    parameter int DW   = 16,
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_en,
    input  logic            acc_dport,
    input  logic            acc_wr,
    input  logic [DW-1:0]   acc_wdata,
    input  logic            adv_en,
    input  logic            adv_wide,
    output logic [AW-1:0]   ptr_q,
    output logic            win_sel,
    output logic [DW-1:0]   reg_rdata
);
    localparam int HW = AW - DW;

    logic [IDXW-1:0] idx_q;
    logic            wr_reg;

    assign win_sel = acc_dport && (idx_q == IDXW'(IDX_WINDOW));
    assign wr_reg  = acc_en && acc_dport && acc_wr;

    // Index register: loaded by writes to the select port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (acc_en && !acc_dport && acc_wr)
            idx_q <= acc_wdata[IDXW-1:0];
    end

    // Address pointer: moves forward after a window transfer, or is loaded by register writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (adv_en)
            ptr_q <= ptr_q + {{(AW-2){1'b0}}, adv_wide, ~adv_wide};
        else if (wr_reg && idx_q == IDXW'(IDX_PTR_LO))
            ptr_q[DW-1:0] <= acc_wdata;
        else if (wr_reg && idx_q == IDXW'(IDX_PTR_HI))
            ptr_q[AW-1:DW] <= acc_wdata[HW-1:0];
    end

    // Read mux for the select port and the register indexes.
    always_comb begin
        reg_rdata = '0;
        if (!acc_dport)
            reg_rdata[IDXW-1:0] = idx_q;
        else if (idx_q == IDXW'(IDX_PTR_LO))
            reg_rdata = ptr_q[DW-1:0];
        else if (idx_q == IDXW'(IDX_PTR_HI))
            reg_rdata[HW-1:0] = ptr_q[AW-1:DW];
    end

endmodule

// File: rtl/sram_ioport_seq.sv
// Byte sequencer: turns one host window access into one or two byte cycles,
// each lasting ACC_CYC clocks, with the lower address first.
// Assumes ACC_CYC >= 2 so that the write strobe can rise before the address moves,
// and that ptr stays stable while busy is high.
module sram_ioport_seq
    import sram_ioport_pkg::*;
#(
    parameter int AW      = 17,
    parameter int BW      = 8,
    parameter int ACC_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            wr,
    input  logic            wide,
    input  logic [2*BW-1:0] wdata,
    input  logic [AW-1:0]   ptr,
    input  logic [BW-1:0]   sram_rdata,
    output logic            busy,
    output logic            done,
    output logic            rd_done,
    output logic [2*BW-1:0] rd_word,
    output logic [AW-1:0]   sram_addr,
    output logic [BW-1:0]   sram_wdata,
    output logic            sram_ce_n,
    output logic            sram_oe_n,
    output logic            sram_we_n
);
    localparam int CW = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;

    seq_state_t      st;
    logic [CW-1:0]   cnt;
    logic            wr_q;
    logic            wide_q;
    logic [2*BW-1:0] wd_q;
    logic [BW-1:0]   lo_q;
    logic            last_tick;

    assign last_tick = (cnt == CW'(ACC_CYC - 1));

    // Phase and cycle counter, with the request fields latched at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SQ_IDLE;
            cnt    <= '0;
            wr_q   <= 1'b0;
            wide_q <= 1'b0;
            wd_q   <= '0;
            lo_q   <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        st     <= SQ_LO;
                        cnt    <= '0;
                        wr_q   <= wr;
                        wide_q <= wide;
                        wd_q   <= wdata;
                    end
                end
                SQ_LO: begin
                    if (last_tick) begin
                        lo_q <= sram_rdata;
                        cnt  <= '0;
                        st   <= wide_q ? SQ_HI : SQ_IDLE;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                SQ_HI: begin
                    if (last_tick) begin
                        cnt <= '0;
                        st  <= SQ_IDLE;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Completion flags and the assembled read word.
    always_comb begin
        done    = last_tick && ((st == SQ_LO && !wide_q) || st == SQ_HI);
        rd_done = done && !wr_q;
        rd_word = (st == SQ_HI) ? {sram_rdata, lo_q} : {{BW{1'b0}}, sram_rdata};
    end

    // SRAM address, data and strobes, decoded from the phase.
    always_comb begin
        busy       = (st != SQ_IDLE);
        sram_addr  = ptr + AW'(st == SQ_HI);
        sram_wdata = (st == SQ_HI) ? wd_q[2*BW-1:BW] : wd_q[BW-1:0];
        sram_ce_n  = !busy;
        sram_oe_n  = !(busy && !wr_q);
        sram_we_n  = !(busy && wr_q && !last_tick);
    end

endmodule

// File: rtl/sram_ioport.sv
// Top of the indirect SRAM access port: an index/data port pair for the host,
// a register block and a byte sequencer. Assumes the host issues host_req
// only while host_ready is 1; requests made while busy are dropped.
// smem_match_n is kept for pin compatibility and is not used.
module sram_ioport
    import sram_ioport_pkg::*;
#(
    parameter int AW      = 17,
    parameter int BW      = 8,
    parameter int IDXW    = 4,
    parameter int ACC_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_wr,
    input  logic             host_dport,
    input  logic             host_wide,
    input  logic [2*BW-1:0]  host_wdata,
    output logic [2*BW-1:0]  host_rdata,
    output logic             host_ready,
    input  logic             smem_match_n,
    output logic [AW-1:0]    sram_addr,
    output logic [BW-1:0]    sram_wdata,
    input  logic [BW-1:0]    sram_rdata,
    output logic             sram_ce_n,
    output logic             sram_oe_n,
    output logic             sram_we_n
);
    localparam int DW = 2 * BW;

    logic            acc_en;
    logic            win_sel;
    logic            busy;
    logic            done;
    logic            rd_done;
    logic [DW-1:0]   rd_word;
    logic [DW-1:0]   reg_rdata;
    logic [AW-1:0]   ptr_w;
    logic [DW-1:0]   rdata_q;
    logic            unused_match;

    assign unused_match = smem_match_n;
    assign host_ready   = !busy;
    assign acc_en       = host_req && !busy;
    assign host_rdata   = rdata_q;

    sram_ioport_regs #(.AW(AW), .DW(DW), .IDXW(IDXW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_dport (host_dport),
        .acc_wr    (host_wr),
        .acc_wdata (host_wdata),
        .adv_en    (done),
        .adv_wide  (rd_word_wide_sel()),
        .ptr_q     (ptr_w),
        .win_sel   (win_sel),
        .reg_rdata (reg_rdata)
    );

    sram_ioport_seq #(.AW(AW), .BW(BW), .ACC_CYC(ACC_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (acc_en && win_sel),
        .wr         (host_wr),
        .wide       (host_wide),
        .wdata      (host_wdata),
        .ptr        (ptr_w),
        .sram_rdata (sram_rdata),
        .busy       (busy),
        .done       (done),
        .rd_done    (rd_done),
        .rd_word    (rd_word),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_ce_n  (sram_ce_n),
        .sram_oe_n  (sram_oe_n),
        .sram_we_n  (sram_we_n)
    );

    // A transfer that finishes in the high byte phase was a 16-bit one.
    function automatic logic rd_word_wide_sel();
        return u_seq.st == SQ_HI;
    endfunction

    // Read data register: loaded by register reads and by completed window reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (acc_en && !host_wr && !win_sel)
            rdata_q <= reg_rdata;
        else if (rd_done)
            rdata_q <= rd_word;
    end

endmodule

// File: rtl/sram_ioport_chk.sv
// Assertion checker for sram_ioport, attached to it with bind.
// Assumes reset is held low for at least one clock at the start.
module sram_ioport_chk #(
    parameter int AW = 17,
    parameter int BW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            host_ready,
    input logic [2*BW-1:0] host_rdata,
    input logic [AW-1:0]   sram_addr,
    input logic            sram_ce_n,
    input logic            sram_oe_n,
    input logic            sram_we_n,
    input logic [AW-1:0]   ptr
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (sram_ce_n && sram_oe_n && sram_we_n)); // R10

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> sram_we_n); // R10

    AST_WE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ready) |-> $past(sram_we_n)); // R6

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && !$past(sram_ce_n)) |->
        (sram_addr == $past(sram_addr) || sram_addr == $past(sram_addr) + AW'(1))); // R4

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ready) |->
        (ptr == $past(ptr) + AW'(1) || ptr == $past(ptr) + AW'(2))); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ready |-> $stable(host_rdata)); // R8

endmodule

bind sram_ioport sram_ioport_chk #(.AW(AW), .BW(BW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ready (host_ready),
    .host_rdata (host_rdata),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .ptr        (ptr_w)
);

// File: tb/test_sram_ioport.sv
// Bench for sram_ioport: a behavioural SRAM, a cycle-by-cycle reference model
// compared on every clock, and directed host transfers with explicit readback checks.
module test_sram_ioport;
    localparam int ACC  = 2;
    localparam int MASK = 32'h1FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_req, host_wr, host_dport, host_wide;
    logic [15:0] host_wdata, host_rdata;
    logic        host_ready, smem_match_n;
    logic [16:0] sram_addr;
    logic [7:0]  sram_wdata, sram_rdata;
    logic        sram_ce_n, sram_oe_n, sram_we_n;

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;
    bit toggle_match = 0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    sram_ioport i_sram_ioport (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_dport(host_dport), .host_wide(host_wide), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ready(host_ready), .smem_match_n(smem_match_n),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
    );

    // Initial SRAM contents, computed from the address.
    function automatic logic [7:0] seed(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    logic [7:0] sram_mem [int];
    logic [7:0] ref_mem  [int];
    int         mem_gen = 0;

    function automatic logic [7:0] sram_peek(input int a);
        return sram_mem.exists(a) ? sram_mem[a] : seed(a);
    endfunction

    function automatic logic [7:0] ref_peek(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : seed(a);
    endfunction

    // Behavioural asynchronous SRAM: combinational read, write while both strobes are low.
    always @(sram_addr, mem_gen) sram_rdata = sram_peek(int'(sram_addr));
    always @(posedge clk)
        if (!sram_ce_n && !sram_we_n) begin
            sram_mem[int'(sram_addr)] = sram_wdata;
            mem_gen = mem_gen + 1;
        end

    // Reference model state.
    int          m_left, m_T, m_ptr, m_idx;
    logic        m_wr, m_wide;
    logic [15:0] m_wd, m_rdata;
    logic [7:0]  m_cap [2];

    // Reference model, advanced once per clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_T = 0; m_ptr = 0; m_idx = 0;
            m_wr = 0; m_wide = 0; m_wd = 0; m_rdata = 0;
        end else if (m_left > 0) begin
            int pos, bsel;
            pos  = m_T - m_left;
            bsel = pos / ACC;
            if ((pos % ACC) == ACC - 1 && !m_wr)
                m_cap[bsel] = ref_peek((m_ptr + bsel) & MASK);
            if (pos == m_T - 1) begin
                if (!m_wr) m_rdata = m_wide ? {m_cap[1], m_cap[0]} : {8'h00, m_cap[0]};
                m_ptr = (m_ptr + (m_wide ? 2 : 1)) & MASK;
            end
            m_left = m_left - 1;
        end else if (host_req) begin
            if (!host_dport) begin
                if (host_wr) m_idx = int'(host_wdata[3:0]);
                else         m_rdata = 16'(m_idx);
            end else begin
                case (m_idx)
                    0: begin
                        m_wr = host_wr; m_wide = host_wide; m_wd = host_wdata;
                        m_T = ACC * (host_wide ? 2 : 1); m_left = m_T;
                        if (host_wr) begin
                            ref_mem[m_ptr] = host_wdata[7:0];
                            if (host_wide) ref_mem[(m_ptr + 1) & MASK] = host_wdata[15:8];
                        end
                    end
                    1: if (host_wr) m_ptr = (m_ptr & 32'h10000) | int'(host_wdata);
                       else         m_rdata = 16'(m_ptr & 32'hFFFF);
                    2: if (host_wr) m_ptr = (m_ptr & 32'hFFFF) | (int'(host_wdata[0]) << 16);
                       else         m_rdata = 16'(m_ptr >> 16);
                    default: if (!host_wr) m_rdata = 16'h0000;
                endcase
            end
        end
    end

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-clock comparison of all outputs against the model, away from the active edge.
    always @(negedge clk) if (!finished) begin
        int pos, bsel;
        bit busy;
        busy = (m_left > 0);
        pos  = m_T - m_left;
        bsel = busy ? pos / ACC : 0;
        cmp(cur_tag, "host_ready", int'(host_ready), int'(!busy));
        cmp(cur_tag, "host_rdata", int'(host_rdata), int'(m_rdata));
        cmp("R10", "sram_ce_n", int'(sram_ce_n), int'(!busy));
        cmp("R10", "sram_oe_n", int'(sram_oe_n), int'(!(busy && !m_wr)));
        cmp("R6", "sram_we_n", int'(sram_we_n), int'(!(busy && m_wr && (pos % ACC) != ACC - 1)));
        if (busy) cmp("R4", "sram_addr", int'(sram_addr), (m_ptr + bsel) & MASK);
        if (!sram_we_n) cmp("R6", "sram_wdata", int'(sram_wdata), int'(bsel != 0 ? m_wd[15:8] : m_wd[7:0]));
    end

    // Memory-match input toggling for the ignored-input test.
    always @(negedge clk) if (toggle_match) smem_match_n <= ~smem_match_n;

    task automatic op(input logic dp, input logic wr, input logic wd, input logic [15:0] d);
        @(negedge clk);
        host_req = 1; host_dport = dp; host_wr = wr; host_wide = wd; host_wdata = d;
        @(negedge clk);
        host_req = 0;
        while (!host_ready) @(negedge clk);
    endtask

    task automatic set_ptr(input int p);
        op(0, 1, 1, 16'd2); op(1, 1, 1, 16'(p >> 16));
        op(0, 1, 1, 16'd1); op(1, 1, 1, 16'(p & 32'hFFFF));
        op(0, 1, 1, 16'd0);
    endtask

    task automatic read_ptr(input string tag, input int exp);
        op(0, 1, 1, 16'd1); op(1, 0, 1, 16'h0);
        cmp(tag, "ptr[15:0]", int'(host_rdata), exp & 32'hFFFF);
        op(0, 1, 1, 16'd2); op(1, 0, 1, 16'h0);
        cmp(tag, "ptr[16]", int'(host_rdata), exp >> 16);
        op(0, 1, 1, 16'd0);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; host_req = 0; host_wr = 0; host_dport = 0; host_wide = 0;
        host_wdata = 0; smem_match_n = 1;
        repeat (4) @(negedge clk);
        // R1: reset values seen at the ports
        cmp("R1", "reset ready", int'(host_ready), 1);
        cmp("R1", "reset rdata", int'(host_rdata), 0);
        cmp("R1", "reset ce_n", int'(sram_ce_n), 1);
        rst_n = 1;
        @(negedge clk);
        op(0, 0, 1, 16'h0);
        cmp("R1", "index after reset", int'(host_rdata), 0);
        read_ptr("R1", 0);

        // R2: index port
        cur_tag = "R2";
        op(0, 1, 1, 16'h0003); op(0, 0, 1, 16'h0);
        cmp("R2", "index 3", int'(host_rdata), 3);
        op(0, 1, 0, 16'hFFF5); op(0, 0, 1, 16'h0);
        cmp("R2", "index upper bits dropped", int'(host_rdata), 5);

        // R3: pointer registers and unused indexes
        cur_tag = "R3";
        op(0, 1, 1, 16'd1); op(1, 1, 0, 16'h1234); op(1, 0, 1, 16'h0);
        cmp("R3", "ptr low readback", int'(host_rdata), 16'h1234);
        op(0, 1, 1, 16'd2); op(1, 1, 1, 16'hFFFF); op(1, 0, 1, 16'h0);
        cmp("R3", "ptr bit16 readback", int'(host_rdata), 1);
        op(0, 1, 1, 16'd3); op(1, 1, 1, 16'hABCD); op(1, 0, 1, 16'h0);
        cmp("R3", "unused index reads 0", int'(host_rdata), 0);
        op(0, 1, 1, 16'd0);
        read_ptr("R3", 32'h11234);

        // R4: 16-bit window read
        cur_tag = "R4";
        set_ptr(32'h00010);
        op(1, 0, 1, 16'h0);
        cmp("R4", "wide read", int'(host_rdata), int'({seed(17), seed(16)}));
        read_ptr("R7", 32'h00012);

        // R5: 8-bit window read
        cur_tag = "R5";
        op(1, 0, 0, 16'h0);
        cmp("R5", "narrow read", int'(host_rdata), int'(seed(18)));
        read_ptr("R7", 32'h00013);

        // R6: writes, checked by reading back
        cur_tag = "R6";
        op(1, 1, 1, 16'hBEEF);
        op(1, 1, 0, 16'hC377);
        set_ptr(32'h00013);
        op(1, 0, 0, 16'h0); cmp("R6", "byte at 0x13", int'(host_rdata), 16'h00EF);
        op(1, 0, 0, 16'h0); cmp("R6", "byte at 0x14", int'(host_rdata), 16'h00BE);
        op(1, 0, 0, 16'h0); cmp("R6", "byte at 0x15", int'(host_rdata), 16'h0077);
        cmp("R6", "byte at 0x16 untouched", int'(sram_peek(32'h16)), int'(seed(32'h16)));
        set_ptr(32'h00013);
        op(1, 0, 1, 16'h0); cmp("R6", "wide readback", int'(host_rdata), 16'hBEEF);

        // R7: wrap at the top of the address space
        cur_tag = "R7";
        set_ptr(32'h1FFFF);
        op(1, 1, 1, 16'hA55A);
        read_ptr("R7", 32'h00001);
        cmp("R7", "wrap byte at 0", int'(sram_peek(0)), 16'hA5);
        set_ptr(32'h1FFFF);
        op(1, 0, 0, 16'h0); cmp("R7", "narrow at top", int'(host_rdata), 16'h005A);
        read_ptr("R7", 0);

        // R8: request during a busy transfer is dropped
        cur_tag = "R8";
        set_ptr(32'h00020);
        @(negedge clk);
        host_req = 1; host_dport = 1; host_wr = 0; host_wide = 1; host_wdata = 0;
        @(negedge clk);
        host_dport = 0; host_wr = 1; host_wdata = 16'h0009;
        @(negedge clk);
        host_req = 0;
        while (!host_ready) @(negedge clk);
        cmp("R8", "read during drop", int'(host_rdata), int'({seed(33), seed(32)}));
        op(0, 0, 1, 16'h0);
        cmp("R8", "index unchanged", int'(host_rdata), 0);
        read_ptr("R8", 32'h00022);

        // R9: toggling memory-match input
        cur_tag = "R9";
        toggle_match = 1;
        set_ptr(32'h00040);
        op(1, 1, 1, 16'h1357);
        set_ptr(32'h00040);
        op(1, 0, 1, 16'h0); cmp("R9", "readback with match toggling", int'(host_rdata), 16'h1357);
        read_ptr("R9", 32'h00042);
        toggle_match = 0;

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule